// File: doc/BRIEF.md
# USB Frame Timeout Watchdog

This block watches a USB device link for signs of life: a start-of-frame token or an end-of-packet keep-alive. A 14-bit down counter, advanced by a 12 MHz tick enable, measures the time since the last such event. Any event reloads the counter from a programmed interval. If the counter runs out first, the block records a timeout. It keeps running after each timeout, so repeated misses are also counted.

Each timeout taken while the interrupt enable is high does three things. It sets a sticky flag, it adds one to a small saturating occurrence counter, and it pulses the interrupt output for one cycle. The next SOF or EOP clears both the flag and the counter. The frame number of the last full-speed SOF is latched next to them. Software reads the flag, the counter and the frame number together as one packed 16-bit status word.

Top module: `frame_timeout_monitor`

## Requirements
- R1: After reset the programmed interval is 0x2EE0, the down counter holds 0x2EE0, `status_o` reads 0x0000 and `irq_o` is low.
- R2: The down counter moves only on cycles with `tick_i` high. After it is loaded with N, the tick that finds it at zero is the expiry, which is the (N+1)th tick. On expiry it reloads the programmed interval and keeps running.
- R3: A write with `wr_en_i` high loads `wr_data_i[13:0]` into both the programmed interval and the down counter. Bits 15:14 of the write are ignored. A write has priority over an event in the same cycle, and a cycle with a write never expires.
- R4: `sof_i` or `eop_i` high reloads the down counter from the programmed interval, and that cycle never expires.
- R5: An expiry while `irq_en_i` is high sets the flag at `status_o[15]` and drives `irq_o` high for exactly the next cycle.
- R6: `status_o[14:12]` adds one for each expiry while `irq_en_i` is high and stays at 7 once it gets there.
- R7: A cycle with `sof_i` or `eop_i` high clears `status_o[15]` and `status_o[14:12]` to 0.
- R8: `sof_i` while `low_speed_i` is low latches `frame_i` into `status_o[10:0]`. The value is held across timeouts and EOPs, and `status_o[11]` always reads 0.
- R9: While `low_speed_i` is high, `sof_i` does not change `status_o[10:0]`. It still reloads the counter and clears the flag and the counter.
- R10: An expiry while `irq_en_i` is low still reloads the down counter but changes neither the flag, the occurrence counter nor `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | 12 MHz tick enable for the down counter |
| wr_en_i | input | 1 | Write strobe for the interval register |
| wr_data_i | input | 16 | Write data; bits 13:0 are the interval |
| sof_i | input | 1 | Start-of-frame token received |
| eop_i | input | 1 | End-of-packet (keep-alive) seen |
| frame_i | input | 11 | Frame number carried by the SOF |
| low_speed_i | input | 1 | Link runs at low speed; frame numbers are not latched |
| irq_en_i | input | 1 | Timeout interrupt enable |
| status_o | output | 16 | {flag, occurrences[2:0], 0, frame[10:0]} |
| irq_o | output | 1 | One-cycle timeout interrupt pulse |

## Verification
The hardest state to reach is counter saturation. It needs eight or more enabled expiries in a row with no SOF or EOP in between, and at the default interval of 0x2EE0 that would take almost 100,000 ticks. The stimulus first runs the full default interval once to confirm the reset count. It then programs intervals of 0 to 3 and holds events off, which walks the counter to 7 and past it within a few dozen cycles. Random phases mix short programmed intervals, sparse events, gaps in the tick and changes of the enable. This makes expiries land on cycles that are next to writes and events.

// File: rtl/fto_pkg.sv
package fto_pkg;
  localparam int CNT_W_DEF   = 14;
  localparam int FRAME_W_DEF = 11;
  localparam int OCC_W_DEF   = 3;
  localparam int WR_W_DEF    = 16;
  localparam int RELOAD_DEF  = 12000; // 1 ms of 12 MHz ticks

  // saturating increment used by the occurrence tally
  function automatic logic [7:0] sat_inc(input logic [7:0] v, input logic [7:0] lim);
    return (v >= lim) ? lim : v + 8'd1;
  endfunction
endpackage

// File: rtl/fto_interval_timer.sv
module fto_interval_timer #(
  parameter int CNT_W   = 14,
  parameter int RST_VAL = 12000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] INIT = CNT_W'(RST_VAL);

  logic [CNT_W-1:0] interval_q;
  logic [CNT_W-1:0] count_q;

  assign expire_o = tick_i && (count_q == '0) && !restart_i && !load_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      interval_q <= INIT;
      count_q    <= INIT;
    end else if (load_i) begin
      interval_q <= load_val_i;
      count_q    <= load_val_i;
    end else if (restart_i) begin
      count_q <= interval_q;
    end else if (tick_i) begin
      count_q <= (count_q == '0) ? interval_q : count_q - 1'b1;
    end
  end
endmodule

// File: rtl/fto_timeout_tally.sv
module fto_timeout_tally
  import fto_pkg::*;
#(
  parameter int OCC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             expire_i,
  input  logic             irq_en_i,
  output logic             flag_o,
  output logic [OCC_W-1:0] occ_o,
  output logic             irq_o
);
  localparam logic [7:0] OCC_MAX = 8'((1 << OCC_W) - 1);

  logic hit;
  assign hit = expire_i && irq_en_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      occ_o  <= '0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= hit && !clear_i;
      if (clear_i) begin
        flag_o <= 1'b0;
        occ_o  <= '0;
      end else if (hit) begin
        flag_o <= 1'b1;
        occ_o  <= OCC_W'(sat_inc(8'(occ_o), OCC_MAX));
      end
    end
  end
endmodule

// File: rtl/fto_frame_latch.sv
module fto_frame_latch #(
  parameter int FRAME_W = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               capture_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [FRAME_W-1:0] frame_o
);
  always_ff @(posedge clk) begin
    if (rst)            frame_o <= '0;
    else if (capture_i) frame_o <= frame_i;
  end
endmodule

// File: rtl/frame_timeout_monitor.sv
module frame_timeout_monitor
  import fto_pkg::*;
#(
  parameter int CNT_W   = CNT_W_DEF,
  parameter int FRAME_W = FRAME_W_DEF,
  parameter int OCC_W   = OCC_W_DEF,
  parameter int WR_W    = WR_W_DEF,
  parameter int RST_VAL = RELOAD_DEF
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              tick_i,
  input  logic                              wr_en_i,
  input  logic [WR_W-1:0]                   wr_data_i,
  input  logic                              sof_i,
  input  logic                              eop_i,
  input  logic [FRAME_W-1:0]                frame_i,
  input  logic                              low_speed_i,
  input  logic                              irq_en_i,
  output logic [FRAME_W+OCC_W+1:0]          status_o,
  output logic                              irq_o
);
  localparam int PAD_W = WR_W - CNT_W;

  logic             link_evt;
  logic             expire;
  logic             flag;
  logic [OCC_W-1:0] occ;
  logic [FRAME_W-1:0] frame_q;
  logic             unused_wr_hi;

  assign link_evt     = sof_i || eop_i;
  assign unused_wr_hi = ^wr_data_i[WR_W-1:WR_W-PAD_W];

  fto_interval_timer #(.CNT_W(CNT_W), .RST_VAL(RST_VAL)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .restart_i  (link_evt),
    .load_i     (wr_en_i),
    .load_val_i (wr_data_i[CNT_W-1:0]),
    .expire_o   (expire)
  );

  fto_timeout_tally #(.OCC_W(OCC_W)) u_tally (
    .clk      (clk),
    .rst      (rst),
    .clear_i  (link_evt),
    .expire_i (expire),
    .irq_en_i (irq_en_i),
    .flag_o   (flag),
    .occ_o    (occ),
    .irq_o    (irq_o)
  );

  fto_frame_latch #(.FRAME_W(FRAME_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .capture_i (sof_i && !low_speed_i),
    .frame_i   (frame_i),
    .frame_o   (frame_q)
  );

  assign status_o = {flag, occ, 1'b0, frame_q};
endmodule

// File: rtl/fto_checker.sv
module fto_checker (
  input logic        clk,
  input logic        rst,
  input logic        sof_i,
  input logic        eop_i,
  input logic        irq_en_i,
  input logic        low_speed_i,
  input logic [15:0] status_o,
  input logic        irq_o
);
  p_irq_needs_en_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(irq_en_i));

  p_irq_sets_flag_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> status_o[15]);

  p_occ_step_r6: assert property (@(posedge clk) disable iff (rst)
    !(sof_i || eop_i) |=> (status_o[14:12] == $past(status_o[14:12])) ||
                          (status_o[14:12] == $past(status_o[14:12]) + 3'd1));

  p_evt_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (sof_i || eop_i) |=> (status_o[15:12] == 4'h0) && !irq_o);

  p_flag_has_count_r6: assert property (@(posedge clk) disable iff (rst)
    status_o[15] |-> (status_o[14:12] != 3'd0));

  p_frame_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !sof_i |=> $stable(status_o[10:0]));

  p_low_speed_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (sof_i && low_speed_i) |=> $stable(status_o[10:0]));
endmodule

bind frame_timeout_monitor fto_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .sof_i       (sof_i),
  .eop_i       (eop_i),
  .irq_en_i    (irq_en_i),
  .low_speed_i (low_speed_i),
  .status_o    (status_o),
  .irq_o       (irq_o)
);

// File: tb/frame_timeout_monitor_tb_top.sv
module frame_timeout_monitor_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        tick_i, wr_en_i, sof_i, eop_i, low_speed_i, irq_en_i;
  logic [15:0] wr_data_i;
  logic [10:0] frame_i;
  logic [15:0] status_o;
  logic        irq_o;

  int n_checks = 0;
  int n_fail   = 0;

  // reference state
  logic [13:0] m_reload, m_cnt;
  logic        m_flag, m_irq;
  logic [2:0]  m_occ;
  logic [10:0] m_frame;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_timeout_monitor dut_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .sof_i(sof_i), .eop_i(eop_i), .frame_i(frame_i), .low_speed_i(low_speed_i),
    .irq_en_i(irq_en_i), .status_o(status_o), .irq_o(irq_o)
  );

  function automatic logic [15:0] exp_status();
    return {m_flag, m_occ, 1'b0, m_frame};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_reload = 14'h2EE0; m_cnt = 14'h2EE0;
    m_flag = 0; m_occ = 0; m_irq = 0; m_frame = 0;
  endtask

  // one clock: apply inputs, advance model, compare after the edge
  task automatic step(input logic tk, input logic sf, input logic ep, input logic [10:0] fr,
                      input logic wr, input logic [15:0] wd, input logic en, input logic ls,
                      input string tag);
    logic evt, expd;
    tick_i = tk; sof_i = sf; eop_i = ep; frame_i = fr;
    wr_en_i = wr; wr_data_i = wd; irq_en_i = en; low_speed_i = ls;
    @(posedge clk);
    evt  = sf | ep;
    expd = tk && (m_cnt == 0) && !evt && !wr;
    if (wr) begin m_reload = wd[13:0]; m_cnt = wd[13:0]; end
    else if (evt) m_cnt = m_reload;
    else if (tk) m_cnt = (m_cnt == 0) ? m_reload : m_cnt - 14'd1;
    m_irq = expd && en;
    if (evt) begin m_flag = 0; m_occ = 0; end
    else if (expd && en) begin m_flag = 1; m_occ = (m_occ == 3'd7) ? 3'd7 : m_occ + 3'd1; end
    if (sf && !ls) m_frame = fr;
    #1;
    check({tag, " status"}, 32'(status_o), 32'(exp_status()));
    check({tag, " irq"}, 32'(irq_o), 32'(m_irq));
  endtask

  task automatic idle(input int n, input logic en, input string tag);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, en, 0, tag);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 190000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : stim
    int irq_count;
    void'($urandom(32'd4711));
    rst = 1; tick_i = 0; wr_en_i = 0; wr_data_i = 0; sof_i = 0; eop_i = 0;
    frame_i = 0; low_speed_i = 0; irq_en_i = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    model_reset();
    // R1: reset state
    check("R1 status", 32'(status_o), 32'h0);
    check("R1 irq", 32'(irq_o), 32'h0);

    // R1/R2: default interval expires on tick 0x2EE0+1
    idle(12000, 1, "R2 default run");
    check("R2 no early irq", 32'(irq_o), 32'h0);
    step(1, 0, 0, 0, 0, 0, 1, 0, "R2 default expiry");
    check("R2 expiry at 12001 ticks", 32'(irq_o), 32'h1);
    check("R5 flag set", 32'(status_o[15]), 32'h1);
    step(1, 0, 0, 0, 0, 0, 1, 0, "R5 pulse one cycle");
    check("R5 irq drops", 32'(irq_o), 32'h0);

    // R8: frame capture, hold across EOP
    step(0, 1, 0, 11'h5A3, 0, 0, 1, 0, "R8 capture");
    check("R8 frame", 32'(status_o[10:0]), 32'h5A3);
    check("R7 cleared", 32'(status_o[15:12]), 32'h0);
    step(0, 0, 1, 11'h111, 0, 0, 1, 0, "R8 eop hold");

    // R3: upper write bits ignored; interval 5 -> expiry on 6th tick
    step(0, 0, 0, 0, 1, 16'hC005, 1, 0, "R3 write");
    idle(5, 1, "R3 count");
    check("R3 not yet", 32'(irq_o), 32'h0);
    step(1, 0, 0, 0, 0, 0, 1, 0, "R3 expiry");
    check("R3 expiry on 6th tick", 32'(irq_o), 32'h1);

    // R2: no tick, no movement
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 0, 0, 1, 0, "R2 tick gated");
    check("R2 gated no irq", 32'(irq_o), 32'h0);

    // R6: saturation with interval 1
    step(0, 0, 1, 0, 1, 16'h0001, 1, 0, "R6 setup");
    idle(40, 1, "R6 saturate");
    check("R6 occ at 7", 32'(status_o[14:12]), 32'h7);
    check("R8 frame held across timeouts", 32'(status_o[10:0]), 32'h5A3);

    // R10: disabled expiries do nothing visible
    step(0, 1, 0, 11'h0F0, 0, 0, 0, 0, "R10 clear");
    irq_count = 0;
    for (int i = 0; i < 30; i++) begin
      step(1, 0, 0, 0, 0, 0, 0, 0, "R10 disabled");
      if (irq_o) irq_count++;
    end
    check("R10 no irq", 32'(irq_count), 32'h0);
    check("R10 no flag/occ", 32'(status_o[15:12]), 32'h0);

    // R9: low speed keeps frame number but still clears
    idle(3, 1, "R9 prime");
    step(0, 1, 0, 11'h7FF, 0, 0, 1, 1, "R9 low speed sof");
    check("R9 frame kept", 32'(status_o[10:0]), 32'h0F0);
    check("R9 cleared", 32'(status_o[15:12]), 32'h0);

    // R4: event restarts interval
    step(0, 0, 0, 0, 1, 16'h0004, 1, 0, "R4 write");
    idle(4, 1, "R4 run");
    step(0, 0, 1, 0, 0, 0, 1, 0, "R4 eop restart");
    idle(4, 1, "R4 rerun");
    check("R4 restarted no irq", 32'(irq_o), 32'h0);

    // mixed random: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 4000; i++) begin
      logic tk, sf, ep, wr, en, ls;
      tk = ($urandom % 4) != 0;
      sf = ($urandom % 23) == 0;
      ep = ($urandom % 31) == 0;
      wr = ($urandom % 97) == 0;
      en = ($urandom % 8) != 0;
      ls = ($urandom % 5) == 0;
      step(tk, sf, ep, 11'($urandom), wr, 16'($urandom % 4) | (16'($urandom) & 16'hC000),
           en, ls, "R2-mix R5 R6 R7 R9 R10 random");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule